// File: doc/BRIEF.md
# Occupancy-Aware FIFO Read Governor

This block drives the read side of a show-ahead byte FIFO whose fill count reaches the reader one cycle late. In every cycle it decides whether to pop the word at the FIFO head. When it pops, it forwards that word downstream with a valid strobe. The decision uses only the reported fill level and the block's own record of recent pops. It never uses the empty flag, because a pop in the cycle that drains the last word is not yet reflected in any status the reader sees.

With threshold `THRESH` (N, at least 2), a pop is issued at full rate while the reported level is N or more. When the level is between 1 and N-1, a pop is issued only if no pop was issued in the previous N-1 cycles. That gap gives every earlier pop time to show up in the level before it is trusted again. A downstream ready input enables reading. A burst counter, held at zero while ready is low, caps each ready period at `BURST_MAX` words.

Top module: `fifo_rd_governor`

## Requirements
- R1: While `rst` is high, `fifo_pop` is 0, and `out_valid` is 0 in the cycle after any cycle with `rst` high.
- R2: When `ds_ready` is 1, `fifo_level >= THRESH` and fewer than `BURST_MAX` pops have occurred in the current ready period, `fifo_pop` is 1 in that same cycle.
- R3: When `fifo_level` is between 1 and `THRESH-1`, `fifo_pop` is 1 only if no pop was issued in the previous `THRESH-1` cycles.
- R4: `fifo_pop` is never 1 while `fifo_level` is 0.
- R5: `fifo_pop` is 0 whenever `ds_ready` is 0. A cycle with `ds_ready` low restarts the burst count at zero.
- R6: At most `BURST_MAX` pops are issued in one continuous run of `ds_ready` high.
- R7: `out_valid` is 1 in exactly the cycles that follow a cycle with `fifo_pop` at 1. In those cycles `out_data` equals the `fifo_data` value seen during that pop.
- R8: With a FIFO whose level lags its contents by one cycle and the default `THRESH` of 2, no pop hits an empty FIFO. The output bytes come out in write order, with no duplicates and none missing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ds_ready | input | 1 | Downstream ready; reading is allowed only while high |
| fifo_level | input | LVL_W | Reported fill count, one cycle stale |
| fifo_data | input | 8 | Head word of the show-ahead FIFO |
| fifo_pop | output | 1 | Pop request to the FIFO, acted on at the next edge |
| out_valid | output | 1 | Strobe marking one forwarded word |
| out_data | output | 8 | Forwarded word |

## Verification
A pre-loaded FIFO drained with ready held high tests the full-rate path. The pops must come back to back until the level falls under the threshold, which separates a correct level gate from one that waits on history. A slow trickle of writes keeps the reported level at 1 and exercises the throttled path. There, a design that trusts a stale non-zero level pops twice in a row and underflows the lagging model. A deep pre-load longer than the burst cap, followed by a short ready drop, shows whether the cap is enforced and whether the counter restarts. Ready held low with data present must produce no pops at all.

// File: rtl/frg_pkg.sv
package frg_pkg;
    localparam int BYTE_W = 8;

    // registered output stage contents
    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] dat;
    } frg_out_t;

    // per-cycle read decision terms
    typedef struct packed {
        logic lvl_full;   // level at or above threshold
        logic lvl_some;   // level non-zero
        logic allow;      // all gates open
        logic pop;
    } frg_dec_t;
endpackage

// File: rtl/frg_history.sv
module frg_history #(
    parameter int HIST_W = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic pop_i,
    output logic recent_o
);
    logic [HIST_W-1:0] hist_d, hist_q;

    generate
        if (HIST_W == 1) begin : g_single
            always_comb hist_d = pop_i;
        end else begin : g_shift
            always_comb hist_d = {hist_q[HIST_W-2:0], pop_i};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= hist_d;
    end

    assign recent_o = |hist_q;
endmodule

// File: rtl/frg_burst_ctr.sv
module frg_burst_ctr #(
    parameter int BURST_MAX = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic ready_i,
    input  logic pop_i,
    output logic done_o
);
    localparam int CNT_W = $clog2(BURST_MAX + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!ready_i) cnt_d = '0;
        else          cnt_d = cnt_q + CNT_W'(pop_i);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q >= CNT_W'(BURST_MAX));
endmodule

// File: rtl/frg_out_stage.sv
module frg_out_stage
    import frg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pop_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic              valid_o,
    output logic [BYTE_W-1:0] data_o
);
    frg_out_t out_d, out_q;

    always_comb begin
        out_d     = out_q;
        out_d.vld = pop_i;
        if (pop_i) out_d.dat = data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign valid_o = out_q.vld;
    assign data_o  = out_q.dat;
endmodule

// File: rtl/fifo_rd_governor.sv
module fifo_rd_governor
    import frg_pkg::*;
#(
    parameter int THRESH    = 2,
    parameter int LVL_W     = 12,
    parameter int BURST_MAX = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ds_ready,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic [BYTE_W-1:0] fifo_data,
    output logic              fifo_pop,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data
);
    localparam int HIST_W = THRESH - 1;

    logic     recent;
    logic     burst_done;
    frg_dec_t dec;

    // R2/R3/R4/R5/R6 decision: trust the stale level only as far as
    // the recent pop history allows
    always_comb begin
        dec          = '0;
        dec.lvl_full = (fifo_level >= LVL_W'(THRESH));
        dec.lvl_some = (fifo_level != '0);
        dec.allow    = !rst && ds_ready && !burst_done;
        dec.pop      = dec.allow && (dec.lvl_full || (dec.lvl_some && !recent));
    end

    assign fifo_pop = dec.pop;

    frg_history #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .pop_i    (dec.pop),
        .recent_o (recent)
    );

    frg_burst_ctr #(.BURST_MAX(BURST_MAX)) u_burst (
        .clk     (clk),
        .rst     (rst),
        .ready_i (ds_ready),
        .pop_i   (dec.pop),
        .done_o  (burst_done)
    );

    frg_out_stage u_out (
        .clk     (clk),
        .rst     (rst),
        .pop_i   (dec.pop),
        .data_i  (fifo_data),
        .valid_o (out_valid),
        .data_o  (out_data)
    );
endmodule

// File: rtl/frg_checker.sv
module frg_checker #(
    parameter int THRESH    = 2,
    parameter int LVL_W     = 12,
    parameter int BURST_MAX = 1024
) (
    input logic             clk,
    input logic             rst,
    input logic             ds_ready,
    input logic [LVL_W-1:0] fifo_level,
    input logic [7:0]       fifo_data,
    input logic             fifo_pop,
    input logic             out_valid,
    input logic [7:0]       out_data
);
    int gap_q;   // idle cycles since last pop, saturating at THRESH
    int bcnt_q;  // pops in current ready period

    always_ff @(posedge clk) begin
        if (rst)                 gap_q <= THRESH;
        else if (fifo_pop)       gap_q <= 0;
        else if (gap_q < THRESH) gap_q <= gap_q + 1;
    end

    always_ff @(posedge clk) begin
        if (rst || !ds_ready) bcnt_q <= 0;
        else if (fifo_pop)    bcnt_q <= bcnt_q + 1;
    end

    a_r1_no_pop_in_reset: assert property (@(posedge clk) rst |-> !fifo_pop);
    a_r1_valid_clear:     assert property (@(posedge clk) rst |=> !out_valid);

    a_r2_full_rate: assert property (@(posedge clk) disable iff (rst)
        (ds_ready && fifo_level >= LVL_W'(THRESH) && bcnt_q < BURST_MAX) |-> fifo_pop);

    a_r3_throttle: assert property (@(posedge clk) disable iff (rst)
        (fifo_pop && fifo_level < LVL_W'(THRESH)) |-> (gap_q >= THRESH - 1));

    a_r4_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> (fifo_level != '0));

    a_r5_ready_gate: assert property (@(posedge clk) disable iff (rst)
        !ds_ready |-> !fifo_pop);

    a_r6_burst_cap: assert property (@(posedge clk) disable iff (rst)
        (bcnt_q >= BURST_MAX) |-> !fifo_pop);

    a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |=> out_valid);
    a_r7_no_extra_valid: assert property (@(posedge clk) disable iff (rst)
        !fifo_pop |=> !out_valid);
    a_r7_data_match: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |=> (out_data == $past(fifo_data)));
endmodule

bind fifo_rd_governor frg_checker #(
    .THRESH    (THRESH),
    .LVL_W     (LVL_W),
    .BURST_MAX (BURST_MAX)
) u_frg_checker (
    .clk        (clk),
    .rst        (rst),
    .ds_ready   (ds_ready),
    .fifo_level (fifo_level),
    .fifo_data  (fifo_data),
    .fifo_pop   (fifo_pop),
    .out_valid  (out_valid),
    .out_data   (out_data)
);

// File: tb/fifo_rd_governor_bench.sv
`timescale 1ns/1ps
module fifo_rd_governor_bench;
    localparam int THRESH    = 2;
    localparam int LVL_W     = 12;
    localparam int BURST_MAX = 1024;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ds_ready = 1'b0;
    logic [LVL_W-1:0] fifo_level;
    logic [7:0]       fifo_data;
    logic             fifo_pop;
    logic             out_valid;
    logic [7:0]       out_data;

    always #2 clk = ~clk;  // 250 MHz

    fifo_rd_governor #(.THRESH(THRESH), .LVL_W(LVL_W), .BURST_MAX(BURST_MAX)) u_fifo_rd_governor (
        .clk(clk), .rst(rst), .ds_ready(ds_ready), .fifo_level(fifo_level),
        .fifo_data(fifo_data), .fifo_pop(fifo_pop), .out_valid(out_valid), .out_data(out_data)
    );

    // behavioural show-ahead FIFO, level reported one cycle late
    logic             wr_en = 1'b0;
    logic [7:0]       wr_data = '0;
    logic [7:0]       mem [0:2047];
    logic [LVL_W-1:0] wp, rp, lvl_q;
    wire  [LVL_W-1:0] count = wp - rp;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0; rp <= '0; lvl_q <= '0;
        end else begin
            lvl_q <= count;
            if (wr_en) begin
                mem[wp[10:0]] <= wr_data;
                wp <= wp + 1'b1;
            end
            if (fifo_pop && count != '0) rp <= rp + 1'b1;
        end
    end
    assign fifo_level = lvl_q;
    assign fifo_data  = mem[rp[10:0]];

    int checks = 0, failures = 0;
    int n_pop = 0, n_val = 0, n_under = 0, n_r3 = 0, n_r4 = 0, n_vtim = 0, n_mism = 0;
    int n_written = 0;
    logic       prev_pop = 1'b0;
    logic [7:0] exp_byte = '0;
    logic [7:0] seq = '0;

    // port monitor, samples mid-cycle
    always @(negedge clk) begin
        if (rst) begin
            prev_pop = 1'b0;
        end else begin
            if (out_valid !== prev_pop) n_vtim++;
            if (out_valid) begin
                n_val++;
                if (out_data !== exp_byte) n_mism++;
                exp_byte = exp_byte + 8'd1;
            end
            if (fifo_pop) begin
                n_pop++;
                if (count == '0) n_under++;
                if (fifo_level == '0) n_r4++;
                if (fifo_level < LVL_W'(THRESH) && prev_pop) n_r3++;
            end
            prev_pop = fifo_pop;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic write_words(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            wr_en = 1'b1; wr_data = seq; seq = seq + 8'd1; n_written++;
            repeat (gap) begin @(posedge clk); #1; wr_en = 1'b0; end
        end
        @(posedge clk); #1; wr_en = 1'b0;
    endtask

    task automatic t_reset;
        cyc(3);
        check("R1 pop in reset", int'(fifo_pop), 0);
        check("R1 valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        cyc(2);
    endtask

    task automatic t_stream;
        int base;
        write_words(20, 0);
        cyc(3);
        check("R5 no pop with ready low", n_pop, 0);
        check("R5 no valid with ready low", int'(out_valid), 0);
        ds_ready = 1'b1;
        base = n_pop;
        cyc(20);
        check("R2 full rate 20 pops in 20 cycles", n_pop - base, 20);
        cyc(5);
        ds_ready = 1'b0;
        cyc(2);
    endtask

    task automatic t_burst;
        int base;
        write_words(1040, 0);
        cyc(3);
        ds_ready = 1'b1;
        base = n_pop;
        cyc(1100);
        check("R6 burst capped", n_pop - base, BURST_MAX);
        ds_ready = 1'b0;
        cyc(2);
        ds_ready = 1'b1;
        base = n_pop;
        cyc(30);
        check("R5 counter restarts after ready drop", n_pop - base, 16);
    endtask

    task automatic t_trickle;
        ds_ready = 1'b1;
        write_words(30, 2);
        write_words(30, 0);
        cyc(10);
        ds_ready = 1'b0;
        cyc(3);
        check("R3 back-to-back pop at low level", n_r3, 0);
        check("R4 pop at level zero", n_r4, 0);
        check("R8 pop on empty FIFO", n_under, 0);
        check("R8 out of order or duplicated byte", n_mism, 0);
        check("R8 all written words forwarded", n_val, n_written);
        check("R7 valid timing errors", n_vtim, 0);
        check("R7 one valid per pop", n_val, n_pop);
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        t_reset;
        t_stream;
        t_burst;
        t_trickle;
        finish_run;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run;
    end
endmodule